// File: doc/BRIEF.md
# SPI Register-Write Receiver

This block is a receive-only serial slave clocked by a fast system clock. It brings the serial clock, serial data and active-low select lines into the system domain through two-flop synchronisers. It finds the rising edges of the serial clock and shifts in one bit on each edge while select is held low. There is no output towards the master.

A frame is exactly 32 bits, sent most significant bit first in SPI mode 0. The first byte of the frame is a register address and the next three bytes are a 24-bit data word. Select works as the write enable. When select returns high after exactly 32 bits, the block gives a one-cycle write strobe, together with the address and data, to a downstream register file or memory port. A frame of any other length is dropped without a trace.

Top module: `spi_reg_write_rx`

## Requirements
- R1: While rst_n is low at a rising clk edge, the block clears wr_en, wr_addr and wr_data to zero.
- R2: Bits are taken only on a rising edge of the synchronised serial clock (low in one sample, high in the next) and enter most significant bit first. Frame bits 31..24 appear on wr_addr and bits 23..0 appear on wr_data.
- R3: A falling edge of select clears the bit count and the shift register, so earlier aborted traffic cannot corrupt the next frame.
- R4: When select rises after exactly 32 sampled bits, wr_en is high for exactly one clk cycle.
- R5: When select rises after fewer than 32 bits (for example 16 or 31), no strobe is produced and wr_addr and wr_data keep their previous values.
- R6: Once 32 bits have been counted, further bits in the same select period are not counted. Instead they mark the frame as overlong (33 or 40 bits, for example), and no strobe is produced.
- R7: Serial clock edges while select is high are ignored. They produce no strobe and leave the outputs unchanged.
- R8: wr_addr and wr_data change only in the cycle in which wr_en is high, and otherwise hold.
- R9: wr_en is high in the third clk cycle after the first rising clk edge that sees spi_cs_n high. This comes from two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, asynchronous |
| spi_mosi | input | 1 | Serial data from the master, asynchronous |
| spi_cs_n | input | 1 | Active-low select, used as the frame write enable |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W (8) | Address byte of the last accepted frame |
| wr_data | output | DATA_W (24) | Data word of the last accepted frame |

## Verification
Full frames use address and data patterns that are all ones, all zeros and alternating. These show whether bits are in the right order and whether the byte split falls in the right place. Frames of 16, 31, 33 and 40 bits separate a counter that is off by one, or that does not saturate, from a correct one. A short aborted frame followed at once by a full frame shows whether select really clears the state. Serial clock toggling while select is high shows whether deselected edges leak into the shift register or the strobe logic. Every strobe is also timed against the cycle in which select rose.

// File: rtl/spi_wr_pkg.sv
// Shared defaults for the SPI register-write receiver.
// Assumes: a frame is one address field followed by one data field.
package spi_wr_pkg;
    localparam int DEF_ADDR_W      = 8;
    localparam int DEF_DATA_W      = 24;
    localparam int DEF_SYNC_STAGES = 2;

    // Total frame length in bits for the given field widths.
    function automatic int frame_bits(input int addr_w, input int data_w);
        return addr_w + data_w;
    endfunction
endpackage

// File: rtl/spi_wr_sync.sv
// Multi-stage flip-flop synchroniser for a bundle of asynchronous lines.
// Assumes: each line is independent; there is no bus coherency across bits.
module spi_wr_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw lines through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_wr_frame.sv
// Frame assembler: detects serial clock rising edges and select edges on
// synchronised lines, shifts bits in MSB first and counts them.
// Assumes: inputs are already synchronised to clk; SPI mode 0.
module spi_wr_frame #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               mosi_s,
    input  logic               csn_s,
    output logic               done,
    output logic [FRAME_W-1:0] frame
);
    localparam int               CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] OVER  = CNT_W'(FRAME_W + 1);

    logic             sclk_q;
    logic             csn_q;
    logic [CNT_W-1:0] count;
    logic [FRAME_W-1:0] shreg;
    logic             sclk_rise;
    logic             sel_fall;
    logic             sel_rise;

    assign sclk_rise = !sclk_q && sclk_s;
    assign sel_fall  = csn_q && !csn_s;
    assign sel_rise  = !csn_q && csn_s;

    // Remember the previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    // Clear on select, shift on clock rises while selected, flag overlong.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            shreg <= '0;
        end else if (sel_fall) begin
            count <= '0;
            shreg <= '0;
        end else if (sclk_rise && !csn_s) begin
            if (count < FULL) begin
                shreg <= {shreg[FRAME_W-2:0], mosi_s};
                count <= count + 1'b1;
            end else begin
                count <= OVER;
            end
        end
    end

    assign done  = sel_rise && (count == FULL);
    assign frame = shreg;

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= OVER);
    p_clear_on_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall |=> (count == '0) && (shreg == '0));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && csn_q) |=> ($stable(count) && $stable(shreg)));
endmodule

// File: rtl/spi_wr_out.sv
// Output stage: registers the write strobe and splits the frame into
// address and data fields, which hold between strobes.
// Assumes: done is a single-cycle pulse.
module spi_wr_out #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     done,
    input  logic [ADDR_W+DATA_W-1:0] frame,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [DATA_W-1:0]        wr_data
);
    localparam int FRAME_W = ADDR_W + DATA_W;

    // Capture fields and raise the strobe for one cycle on a valid frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= done;
            if (done) begin
                wr_addr <= frame[FRAME_W-1 -: ADDR_W];
                wr_data <= frame[DATA_W-1:0];
            end
        end
    end

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/spi_reg_write_rx.sv
// Top of the receive-only SPI register-write slave.
// Assumes: serial clock far slower than clk; one master; active-low select.
module spi_reg_write_rx
    import spi_wr_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int FRAME_W = frame_bits(ADDR_W, DATA_W);

    logic [2:0]         lines_s;
    logic               done;
    logic [FRAME_W-1:0] frame;

    spi_wr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_mosi, spi_sclk}),
        .q     (lines_s)
    );

    spi_wr_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (lines_s[0]),
        .mosi_s (lines_s[1]),
        .csn_s  (lines_s[2]),
        .done   (done),
        .frame  (frame)
    );

    spi_wr_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .frame   (frame),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );
endmodule

// File: tb/sim_spi_reg_write_rx.sv
module sim_spi_reg_write_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [23:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit prev_wr = 1'b0;
    bit finished = 1'b0;
    logic [7:0]  last_addr = '0;
    logic [23:0] last_data = '0;

    typedef struct {
        logic [7:0]  a;
        logic [23:0] d;
        int          at;
    } exp_t;
    exp_t q[$];

    localparam int HALF = 6;

    spi_reg_write_rx u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: sends nbits from bits (MSB first); pushes expectation if full.
    task automatic send(input logic [63:0] bits, input int nbits, input bit expect_wr);
        exp_t e;
        wait_clk(2);
        spi_cs_n = 1'b0;
        wait_clk(5);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = bits[nbits-1-i];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(4);
        spi_cs_n = 1'b1;
        if (expect_wr) begin
            e.a = bits[31:24];
            e.d = bits[23:0];
            e.at = cyc + 3;
            q.push_back(e);
            last_addr = e.a;
            last_data = e.d;
        end
        wait_clk(12);
    endtask

    task automatic check_held(input string req);
        chk(wr_addr == last_addr, req, wr_addr, last_addr);
        chk(wr_data == last_data, req, wr_data, last_data);
    endtask

    // Monitor: pops the scoreboard on each strobe and compares.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                chk(!prev_wr, "R4 strobe longer than one cycle", 1, 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R5/R6/R7 unexpected strobe", wr_addr, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(wr_addr == e.a, "R2 address field", wr_addr, e.a);
                    chk(wr_data == e.d, "R2 data field", wr_data, e.d);
                    chk(cyc == e.at, "R9 strobe latency", cyc, e.at);
                end
            end
            prev_wr = wr_en;
        end
    end

    initial begin
        wait_clk(5);
        // R1 reset state
        chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
        chk(wr_addr == '0, "R1 wr_addr after reset", wr_addr, 0);
        chk(wr_data == '0, "R1 wr_data after reset", wr_data, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R2 R4 R9 full frames with distinct patterns
        send(64'h00000000_A5123456, 32, 1'b1);
        send(64'h00000000_FFFFFFFF, 32, 1'b1);
        send(64'h00000000_00000000, 32, 1'b1);
        send(64'h00000000_3C5A0F81, 32, 1'b1);
        chk(q.size() == 0, "R4 all full frames strobed", q.size(), 0);

        // R5 short frames are dropped
        send(64'h00000000_0000BEEF, 16, 1'b0);
        check_held("R5 after 16-bit frame");
        send(64'h00000000_7EDCBA98, 31, 1'b0);
        check_held("R5 after 31-bit frame");

        // R6 overlong frames are dropped
        send(64'h00000001_23456789, 33, 1'b0);
        check_held("R6 after 33-bit frame");
        send(64'h000000C3_11223344, 40, 1'b0);
        check_held("R6 after 40-bit frame");

        // R7 clock toggling while deselected
        spi_mosi = 1'b1;
        for (int i = 0; i < 40; i++) begin
            wait_clk(HALF);
            spi_sclk = ~spi_sclk;
        end
        spi_sclk = 1'b0;
        wait_clk(12);
        check_held("R7 after deselected clocking");

        // R3 aborted partial frame, then a full frame
        send(64'h00000000_000000FF, 8, 1'b0);
        send(64'h00000000_C0FFEE11, 32, 1'b1);
        chk(q.size() == 0, "R3 frame after abort strobed", q.size(), 0);
        check_held("R8 fields hold after strobe");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule